// File: doc/BRIEF.md
# Periodic Oscillator Trim Corrector

This block compensates a slow crystal oscillator's drift. Once per correction period it either inserts or suppresses a fixed number of oscillator pulses in the count stream that feeds a calendar prescaler. The period is 20 or 60 seconds. The prescaler itself sits outside the block. It reaches the block through three signals: a per-pulse strobe coming in, a one-second strobe coming in, and a pair of count controls going out. The `cnt_en` control tells the prescaler to count the current pulse. The `cnt_extra` control tells it to count one further pulse on top of that.

Software writes an 8-bit trim word. The word holds three fields: a 6-bit amount, a direction flag and a period flag. The word is held as pending and `busy` is raised. At the next period boundary the pending word becomes the active one, and `busy` drops. Each correction step is worth two pulses. When adding, the amount is stored offset by one. When removing, it is stored as a 6-bit complement plus one. Software is expected to wait for `busy` to clear before it writes again. The whole mechanism runs only while the pulse-correction mode input is set.

Top module: `trim_corrector`

## Requirements
- R1: After reset `busy` is 0 and no correction is loaded: `cnt_en` equals `osc_tick` and `cnt_extra` is 0. Neither count output is ever high without `osc_tick`.
- R2: The cycle after a write (`wr_en` high), `busy` reads 1. It stays 1 until the write is applied.
- R3: Every `sec_tick` advances a second counter while the mode is on. The boundary is the `sec_tick` that completes the active period. At that edge the pending word becomes active and `busy` clears.
- R4: Trim word layout: bit 7 selects the period, bit 6 is the direction (1 = remove), and bits 5:0 are the amount v. With direction 0 and v ≥ 1 the step count is v−1. For the first 2·(v−1) `osc_tick` pulses after the boundary, `cnt_extra` is high together with `cnt_en`.
- R5: With direction 1 and v ≥ 1 the step count is (bitwise complement of v in 6 bits)+1. `cnt_en` is held low on the first 2·steps `osc_tick` pulses after the boundary.
- R6: An amount of 0 gives no correction in either direction.
- R7: The step count is capped at 62, so at most 124 pulses are corrected. Removing with v=1 gives 62 steps, and adding with v=63 gives 62 steps.
- R8: The active word is reapplied at every later boundary, with no further write needed.
- R9: While `mode_sel` is 0, `cnt_en` follows `osc_tick`, `cnt_extra` stays 0, the second counter is cleared and any unfinished correction is dropped. A pending word stays pending with `busy` at 1.
- R10: When bit 7 of the active word is 1, the period is 60 seconds; when it is 0, the period is 20 seconds. A new word's period takes effect after the boundary that applies it.
- R11: A second write before the boundary replaces the pending word, and only the last one is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 1 | Enables pulse-correction mode |
| osc_tick | input | 1 | One-cycle strobe per oscillator pulse |
| sec_tick | input | 1 | One-cycle strobe per elapsed second from the prescaler |
| wr_en | input | 1 | Software write strobe for the trim word |
| wr_data | input | 8 | Trim word: period flag, direction flag, 6-bit amount |
| busy | output | 1 | A written word is waiting for the next boundary |
| cnt_en | output | 1 | Prescaler counts this oscillator pulse |
| cnt_extra | output | 1 | Prescaler counts one added pulse on top |

## Verification
A wrong pulse counter shows up at the ports within one correction window, at most 124 oscillator pulses after a boundary. It appears as a wrong number of held or extra counts. A fault in the second counter or the period select moves the boundary. That shows up as `busy` clearing at the wrong second, or as a correction that appears too early or too late in the second period. Faults in the pending/active latch show up one period later, as a wrong or missing repeat correction.

// File: rtl/trim_pkg.sv
// Package: shared types and trim-word decoding for the trim corrector.
// Assumes the 6-bit amount encoding in which adding uses an offset of one
// and removing uses a complement plus one; every step is two pulses.
package trim_pkg;
    localparam int TRIM_AMT_W = 6;
    localparam int TRIM_W     = TRIM_AMT_W + 2;
    localparam int STEP_W     = TRIM_AMT_W + 1;
    localparam int PULSE_W    = TRIM_AMT_W + 2;

    typedef struct packed {
        logic                  long_period;
        logic                  remove;
        logic [TRIM_AMT_W-1:0] amount;
    } trim_cfg_t;

    // Number of pulses (two per step) requested by a trim word, capped.
    function automatic logic [PULSE_W-1:0] trim_pulses(trim_cfg_t c, int unsigned max_steps);
        logic [STEP_W-1:0] steps;
        if (c.amount == '0)
            steps = '0;
        else if (!c.remove)
            steps = {1'b0, c.amount} - STEP_W'(1);
        else
            steps = {1'b0, ~c.amount} + STEP_W'(1);
        if (steps > STEP_W'(max_steps))
            steps = STEP_W'(max_steps);
        return {steps, 1'b0};
    endfunction
endpackage

// File: rtl/trim_period_timer.sv
// Period timer: counts one-second strobes and flags the boundary at the end
// of a short or long correction period. Assumes sec_tick is a one-cycle pulse.
// The count is cleared while run is low.
module trim_period_timer #(
    parameter int SHORT_SECS = 20,
    parameter int LONG_SECS  = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sec_tick,
    input  logic long_sel,
    output logic boundary
);
    localparam int CW = $clog2(LONG_SECS);

    logic [CW-1:0] sec_cnt;
    logic [CW-1:0] limit;

    assign limit    = long_sel ? CW'(LONG_SECS - 1) : CW'(SHORT_SECS - 1);
    assign boundary = run && sec_tick && (sec_cnt >= limit);

    // Second counter: wraps at the boundary, held clear when mode is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            sec_cnt <= '0;
        else if (sec_tick)
            sec_cnt <= boundary ? '0 : sec_cnt + CW'(1);
    end

    p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sec_cnt <= CW'(LONG_SECS - 1));
    p_halt_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> sec_cnt == '0);
    p_still_without_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !sec_tick) |=> $stable(sec_cnt));
endmodule

// File: rtl/trim_cfg_latch.sv
// Config latch: holds the software-written trim word as pending, raises busy,
// and moves it to the active copy at the next period boundary. Assumes software
// waits for busy to drop; a later write simply replaces the pending word.
module trim_cfg_latch
    import trim_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  trim_cfg_t wr_cfg,
    input  logic      boundary,
    output logic      busy,
    output trim_cfg_t active,
    output trim_cfg_t load_cfg
);
    trim_cfg_t pending;

    // Word that takes effect at the current boundary.
    assign load_cfg = busy ? pending : active;

    // Pending/active registers and the busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
            active  <= '0;
            busy    <= 1'b0;
        end else begin
            if (boundary && busy)
                active <= pending;
            if (wr_en) begin
                pending <= wr_cfg;
                busy    <= 1'b1;
            end else if (boundary) begin
                busy    <= 1'b0;
            end
        end
    end

    p_busy_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> busy);
    p_busy_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !wr_en) |=> !busy);
    p_active_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(active));
endmodule

// File: rtl/trim_pulse_shaper.sv
// Pulse shaper: after each boundary it adds or suppresses the decoded number
// of oscillator pulses on the prescaler count controls. Assumes osc_tick is a
// one-cycle strobe; the boundary cycle's own tick is passed unchanged.
module trim_pulse_shaper
    import trim_pkg::*;
#(
    parameter int MAX_STEPS = 62
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  logic      osc_tick,
    input  logic      load,
    input  trim_cfg_t load_cfg,
    output logic      cnt_en,
    output logic      cnt_extra
);
    logic [PULSE_W-1:0] rem;
    logic               remove_q;
    logic               correcting;

    assign correcting = run && (rem != '0);
    assign cnt_en     = osc_tick && !(correcting && remove_q);
    assign cnt_extra  = osc_tick && correcting && !remove_q;

    // Remaining-pulse counter, reloaded at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            rem      <= '0;
            remove_q <= 1'b0;
        end else if (load) begin
            rem      <= trim_pulses(load_cfg, MAX_STEPS);
            remove_q <= load_cfg.remove;
        end else if (osc_tick && rem != '0) begin
            rem      <= rem - PULSE_W'(1);
        end
    end

    p_quiet_without_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_tick |-> (!cnt_en && !cnt_extra));
    p_rem_capped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rem <= PULSE_W'(2 * MAX_STEPS));
    p_rem_steps_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && osc_tick && rem != '0) |=> rem == $past(rem) - PULSE_W'(1));
    p_drop_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> rem == '0);
endmodule

// File: rtl/trim_corrector.sv
// Top: periodic oscillator trim corrector. Ties the period timer, the config
// latch and the pulse shaper together. Assumes the prescaler supplies a
// one-second strobe and honours cnt_en / cnt_extra on each oscillator pulse.
module trim_corrector
    import trim_pkg::*;
#(
    parameter int SHORT_SECS = 20,
    parameter int LONG_SECS  = 60,
    parameter int MAX_STEPS  = 62
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic              osc_tick,
    input  logic              sec_tick,
    input  logic              wr_en,
    input  logic [TRIM_W-1:0] wr_data,
    output logic              busy,
    output logic              cnt_en,
    output logic              cnt_extra
);
    trim_cfg_t active;
    trim_cfg_t load_cfg;
    logic      boundary;

    trim_period_timer #(
        .SHORT_SECS(SHORT_SECS),
        .LONG_SECS (LONG_SECS)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (mode_sel),
        .sec_tick(sec_tick),
        .long_sel(active.long_period),
        .boundary(boundary)
    );

    trim_cfg_latch u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_cfg  (trim_cfg_t'(wr_data)),
        .boundary(boundary),
        .busy    (busy),
        .active  (active),
        .load_cfg(load_cfg)
    );

    trim_pulse_shaper #(
        .MAX_STEPS(MAX_STEPS)
    ) u_shaper (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (mode_sel),
        .osc_tick (osc_tick),
        .load     (boundary),
        .load_cfg (load_cfg),
        .cnt_en   (cnt_en),
        .cnt_extra(cnt_extra)
    );

    p_exclusive_controls_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_extra |-> cnt_en);
endmodule

// File: tb/trim_corrector_test.sv
module trim_corrector_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_sel = 1'b1;
    logic       osc_tick = 1'b0;
    logic       sec_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       busy, cnt_en, cnt_extra;
    int         checks = 0;
    int         fails = 0;

    always #2 clk = ~clk;

    trim_corrector uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .osc_tick(osc_tick),
        .sec_tick(sec_tick), .wr_en(wr_en), .wr_data(wr_data),
        .busy(busy), .cnt_en(cnt_en), .cnt_extra(cnt_extra)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; osc_tick = 1'b0; sec_tick = 1'b0;
        wr_en = 1'b0; wr_data = 8'h00; mode_sel = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_cfg(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic seconds(input int n);
        repeat (n) begin
            sec_tick = 1'b1;
            @(negedge clk);
            sec_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic ticks(input int n, output int en, output int ex);
        en = 0; ex = 0;
        repeat (n) begin
            osc_tick = 1'b1;
            #1;
            en += int'(cnt_en);
            ex += int'(cnt_extra);
            @(negedge clk);
        end
        osc_tick = 1'b0;
    endtask

    task automatic t_reset();
        int en, ex;
        do_reset();
        check("R1 busy after reset", int'(busy), 0);
        ticks(10, en, ex);
        check("R1 counts pass through", en, 10);
        check("R1 no extra", ex, 0);
        #1;
        check("R1 idle controls", int'(cnt_en) + int'(cnt_extra), 0);
    endtask

    task automatic t_add();
        int en, ex;
        do_reset();
        write_cfg(8'h05);  // add, v=5 -> 4 steps -> 8 extra
        check("R2 busy after write", int'(busy), 1);
        seconds(19);
        check("R3 busy before boundary", int'(busy), 1);
        ticks(5, en, ex);
        check("R3 nothing before boundary", ex, 0);
        seconds(1);
        check("R3 busy cleared at boundary", int'(busy), 0);
        ticks(20, en, ex);
        check("R4 extra pulses", ex, 8);
        check("R4 counts kept", en, 20);
        seconds(20);
        ticks(20, en, ex);
        check("R8 repeat extra pulses", ex, 8);
    endtask

    task automatic t_remove();
        int en, ex;
        do_reset();
        write_cfg(8'h7D);  // remove, v=61 -> ~61=2, +1 = 3 steps -> 6 holds
        seconds(20);
        ticks(20, en, ex);
        check("R5 held pulses", en, 14);
        check("R5 no extra when removing", ex, 0);
    endtask

    task automatic t_zero();
        int en, ex;
        do_reset();
        write_cfg(8'h40);
        seconds(20);
        ticks(20, en, ex);
        check("R6 remove zero counts", en, 20);
        do_reset();
        write_cfg(8'h00);
        seconds(20);
        ticks(20, en, ex);
        check("R6 add zero extras", ex, 0);
    endtask

    task automatic t_clamp();
        int en, ex;
        do_reset();
        write_cfg(8'h41);  // remove, v=1 -> 63 capped to 62 -> 124 holds
        seconds(20);
        ticks(150, en, ex);
        check("R7 remove cap", en, 26);
        do_reset();
        write_cfg(8'h3F);  // add, v=63 -> 62 steps -> 124 extra
        seconds(20);
        ticks(150, en, ex);
        check("R7 add max", ex, 124);
    endtask

    task automatic t_long();
        int en, ex;
        do_reset();
        write_cfg(8'h83);  // long period, add v=3 -> 2 steps -> 4 extra
        seconds(20);       // first application uses the reset (short) period
        check("R10 applied at short boundary", int'(busy), 0);
        ticks(10, en, ex);
        check("R10 first correction", ex, 4);
        seconds(59);
        ticks(10, en, ex);
        check("R10 no correction at 59 s", ex, 0);
        seconds(1);
        ticks(10, en, ex);
        check("R10 correction at 60 s", ex, 4);
    endtask

    task automatic t_mode_off();
        int en, ex;
        do_reset();
        write_cfg(8'h05);
        mode_sel = 1'b0;
        seconds(20);
        check("R9 still busy when off", int'(busy), 1);
        ticks(20, en, ex);
        check("R9 pass through when off", en, 20);
        check("R9 no extra when off", ex, 0);
        mode_sel = 1'b1;
        seconds(19);
        check("R9 timer restarted", int'(busy), 1);
        seconds(1);
        ticks(3, en, ex);
        mode_sel = 1'b0;
        @(negedge clk);
        ticks(10, en, ex);
        check("R9 correction dropped", ex, 0);
    endtask

    task automatic t_overwrite();
        int en, ex;
        do_reset();
        write_cfg(8'h05);
        write_cfg(8'h03);  // replaces: 2 steps -> 4 extra
        seconds(20);
        ticks(20, en, ex);
        check("R11 last write applied", ex, 4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_add();
        t_remove();
        t_zero();
        t_clamp();
        t_long();
        t_mode_off();
        t_overwrite();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule